// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the memory traffic of a subroutine call or a subroutine return on behalf of a processor pipeline. When a start strobe arrives with an operation code, the sequencer latches the current program counter, the branch target, the stack pointer and the frame pointer. It then walks a short state machine that issues two 32-bit word accesses on a simple request/acknowledge memory port, one at a time. Each access waits for its acknowledge before the machine moves on. When the last access is acknowledged, the block presents the updated stack pointer, frame pointer and program counter, together with a one-cycle done pulse.

A call frame takes three words below the incoming stack pointer. The word at SP-4 is a spare slot kept for a static-chain pointer and is never written. The return address goes at SP-8. The caller's frame pointer goes at SP-12, and both the new SP and the new FP then point at that word. A return reverses this. It takes the frame pointer as the base, reloads the old frame pointer from that address and the return address from the word above it, and leaves SP twelve bytes above the old FP. Instruction decode and the register file live outside the block.

States: `ST_IDLE` waits for a strobe. `ST_PUSH_RA` writes the return address. `ST_PUSH_FP` writes the caller frame pointer. `ST_POP_FP` reads the saved frame pointer. `ST_POP_PC` reads the return address. `ST_FINISH` raises done for one cycle. Transitions:
- Start of a call: `ST_IDLE` goes to `ST_PUSH_RA`.
- Start of a return: `ST_IDLE` goes to `ST_POP_FP`.
- A reserved code leaves the machine in `ST_IDLE`.
- An acknowledge moves `ST_PUSH_RA` to `ST_PUSH_FP` and `ST_POP_FP` to `ST_POP_PC`.
- An acknowledge moves `ST_PUSH_FP` or `ST_POP_PC` to `ST_FINISH`.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `frame_seq`

## Requirements
- R1: Operation code 2'b00 (call to an absolute target) first writes the return address, equal to the PC input plus 6, to address SP-8 (mod 2^32).
- R2: Operation code 2'b01 (call through a register) first writes PC+2 to address SP-8, and completes with the program counter output equal to the target input.
- R3: Both call forms write the incoming FP to address SP-12 as the second access, and complete with the stack pointer and frame pointer outputs both equal to SP-12; the absolute call also completes with the program counter output equal to the target input.
- R4: Operation code 2'b10 (return) first reads the word at address FP, and the frame pointer output becomes that word; the stack pointer input is not used.
- R5: A return then reads the word at FP+4, the program counter output becomes that word, and the stack pointer output becomes FP+12.
- R6: While a request is raised and not acknowledged, the address, write enable and write data stay unchanged and the sequence does not advance.
- R7: Done is high for exactly one cycle, the cycle after the acknowledge of the second access. Busy is high from the cycle after an accepted start through the done cycle. A request is raised only while busy.
- R8: A start strobe while busy is ignored, and so is a start with the reserved code 2'b11. The result outputs change only in the done cycle.
- R9: Writes drive all four byte enables high. Call accesses are writes and return accesses are reads (write enable low).
- R10: After reset the block is idle: busy, done and request are low, and the SP, FP and PC outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, taken only when idle |
| op | input | 2 | 00 absolute call, 01 register call, 10 return, 11 reserved |
| pc_in | input | 32 | Address of the call instruction |
| target_in | input | 32 | Call destination (immediate or register value) |
| sp_in | input | 32 | Current stack pointer |
| fp_in | input | 32 | Current frame pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Resulting stack pointer |
| fp_out | output | 32 | Resulting frame pointer |
| pc_out | output | 32 | Resulting program counter |

## Verification
The hardest situation to reach from the ports is a second start strobe that lands in the middle of a stalled access. A faulty design could either restart or pick up the new operands there. The stimulus holds back the acknowledge for several cycles on the first access of a call. During that wait it pulses start with a return code and different operands. It then confirms that the frame addresses, write data and final SP/FP/PC still belong to the original call. Address wrap-around below zero and a return address that wraps past 2^32 are also driven through the vector table.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [1:0] {
        OP_CALL_ABS = 2'b00,
        OP_CALL_REG = 2'b01,
        OP_RETURN   = 2'b10,
        OP_RSVD     = 2'b11
    } frame_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_RA = 3'd1,
        ST_PUSH_FP = 3'd2,
        ST_POP_FP  = 3'd3,
        ST_POP_PC  = 3'd4,
        ST_FINISH  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import frame_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  frame_op_e  op,
    input  logic       mem_ack,
    output seq_state_e state,
    output logic       accept,
    output logic       pop_fp_ack,
    output logic       last_ack,
    output logic       mem_req,
    output logic       mem_we,
    output logic       busy,
    output logic       done
);

    seq_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (op == OP_CALL_ABS || op == OP_CALL_REG) state_nx = ST_PUSH_RA;
                    else if (op == OP_RETURN)                   state_nx = ST_POP_FP;
                end
            end
            ST_PUSH_RA: if (mem_ack) state_nx = ST_PUSH_FP;
            ST_PUSH_FP: if (mem_ack) state_nx = ST_FINISH;
            ST_POP_FP:  if (mem_ack) state_nx = ST_POP_PC;
            ST_POP_PC:  if (mem_ack) state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        accept     = 1'b0;
        pop_fp_ack = 1'b0;
        last_ack   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start && (op != OP_RSVD);
            end
            ST_PUSH_RA: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_PUSH_FP: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                last_ack = mem_ack;
            end
            ST_POP_FP: begin
                mem_req    = 1'b1;
                pop_fp_ack = mem_ack;
            end
            ST_POP_PC: begin
                mem_req  = 1'b1;
                last_ack = mem_ack;
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/frame_dp.sv
module frame_dp
    import frame_seq_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int SHORT_LEN = 2,
    parameter int LONG_LEN  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_e      state,
    input  logic            accept,
    input  logic            pop_fp_ack,
    input  logic            last_ack,
    input  frame_op_e       op,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] target_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] fp_in,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [XLEN-1:0] sp_out,
    output logic [XLEN-1:0] fp_out,
    output logic [XLEN-1:0] pc_out
);

    localparam int WORD_B    = XLEN / 8;
    localparam int RA_OFS    = 2 * WORD_B;
    localparam int LINK_OFS  = 3 * WORD_B;
    localparam logic [XLEN-1:0] RA_OFS_V    = XLEN'(RA_OFS);
    localparam logic [XLEN-1:0] LINK_OFS_V  = XLEN'(LINK_OFS);
    localparam logic [XLEN-1:0] WORD_V      = XLEN'(WORD_B);
    localparam logic [XLEN-1:0] SHORT_V     = XLEN'(SHORT_LEN);
    localparam logic [XLEN-1:0] LONG_V      = XLEN'(LONG_LEN);

    logic [XLEN-1:0] base_sp, base_fp, link_pc, dest_pc, saved_fp;
    logic [XLEN-1:0] frame_top;

    assign frame_top = base_sp - LINK_OFS_V;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_sp <= '0;
            base_fp <= '0;
            link_pc <= '0;
            dest_pc <= '0;
        end else if (accept) begin
            base_sp <= sp_in;
            base_fp <= fp_in;
            link_pc <= pc_in + ((op == OP_CALL_ABS) ? LONG_V : SHORT_V);
            dest_pc <= target_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          saved_fp <= '0;
        else if (pop_fp_ack) saved_fp <= mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_out <= '0;
            fp_out <= '0;
            pc_out <= '0;
        end else if (last_ack) begin
            if (state == ST_PUSH_FP) begin
                sp_out <= frame_top;
                fp_out <= frame_top;
                pc_out <= dest_pc;
            end else begin
                sp_out <= base_fp + LINK_OFS_V;
                fp_out <= saved_fp;
                pc_out <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_RA: begin
                mem_addr  = base_sp - RA_OFS_V;
                mem_wdata = link_pc;
            end
            ST_PUSH_FP: begin
                mem_addr  = frame_top;
                mem_wdata = base_fp;
            end
            ST_POP_FP:  mem_addr = base_fp;
            ST_POP_PC:  mem_addr = base_fp + WORD_V;
            default: begin
                mem_addr  = '0;
                mem_wdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int SHORT_LEN = 2,
    parameter int LONG_LEN  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   target_in,
    input  logic [XLEN-1:0]   sp_in,
    input  logic [XLEN-1:0]   fp_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   sp_out,
    output logic [XLEN-1:0]   fp_out,
    output logic [XLEN-1:0]   pc_out
);

    localparam int BE_W = XLEN / 8;

    seq_state_e state;
    frame_op_e  op_e;
    logic       accept, pop_fp_ack, last_ack;

    assign op_e = frame_op_e'(op);

    generate
        for (genvar b = 0; b < BE_W; b++) begin : g_be
            assign mem_be[b] = mem_we;
        end
    endgenerate

    frame_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op_e),
        .mem_ack    (mem_ack),
        .state      (state),
        .accept     (accept),
        .pop_fp_ack (pop_fp_ack),
        .last_ack   (last_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .busy       (busy),
        .done       (done)
    );

    frame_dp #(
        .XLEN      (XLEN),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .pop_fp_ack (pop_fp_ack),
        .last_ack   (last_ack),
        .op         (op_e),
        .pc_in      (pc_in),
        .target_in  (target_in),
        .sp_in      (sp_in),
        .fp_in      (fp_in),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .sp_out     (sp_out),
        .fp_out     (fp_out),
        .pc_out     (pc_out)
    );

endmodule

// File: rtl/frame_seq_checker.sv
module frame_seq_checker #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [XLEN/8-1:0] mem_be,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              mem_ack,
    input logic              busy,
    input logic              done,
    input logic [XLEN-1:0]   sp_out,
    input logic [XLEN-1:0]   fp_out,
    input logic [XLEN-1:0]   pc_out
);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_full_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == '1));

    assert_call_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_we)) |-> (sp_out == fp_out));

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    assert_out_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(sp_out) && $stable(fp_out) && $stable(pc_out)) |-> done);

endmodule

bind frame_seq frame_seq_checker #(.XLEN(XLEN)) u_frame_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done),
    .sp_out    (sp_out),
    .fp_out    (fp_out),
    .pc_out    (pc_out)
);

// File: tb/frame_seq_bench.sv
`timescale 1ns/1ps
module frame_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] pc_in = '0, target_in = '0, sp_in = '0, fp_in = '0;
    logic        mem_req, mem_we, busy, done;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata, sp_out, fp_out, pc_out;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_seq u_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .pc_in(pc_in), .target_in(target_in), .sp_in(sp_in), .fp_in(fp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done),
        .sp_out(sp_out), .fp_out(fp_out), .pc_out(pc_out)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] pc, tgt, sp, fp, rd0, rd1;
        logic [31:0] a0, d0, a1, d1;
        logic [31:0] esp, efp, epc;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h0000_1000, 32'h0000_2000, 32'h0000_8000, 32'h0000_8010, 32'h0, 32'h0,
          32'h0000_7FF8, 32'h0000_1006, 32'h0000_7FF4, 32'h0000_8010,
          32'h0000_7FF4, 32'h0000_7FF4, 32'h0000_2000, 2'd2},
        '{2'd1, 32'h0000_3ABC, 32'h0040_0000, 32'h0001_0000, 32'hCAFE_0000, 32'h0, 32'h0,
          32'h0000_FFF8, 32'h0000_3ABE, 32'h0000_FFF4, 32'hCAFE_0000,
          32'h0000_FFF4, 32'h0000_FFF4, 32'h0040_0000, 2'd0},
        '{2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0100, 32'h0000_7FF4, 32'h0000_8010, 32'h0000_1006,
          32'h0000_7FF4, 32'h0, 32'h0000_7FF8, 32'h0,
          32'h0000_8000, 32'h0000_8010, 32'h0000_1006, 2'd1},
        '{2'd0, 32'hFFFF_FFFC, 32'h0000_0044, 32'h0000_0004, 32'h1234_5678, 32'h0, 32'h0,
          32'hFFFF_FFFC, 32'h0000_0002, 32'hFFFF_FFF8, 32'h1234_5678,
          32'hFFFF_FFF8, 32'hFFFF_FFF8, 32'h0000_0044, 2'd3},
        '{2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFF8, 32'hA5A5_0000, 32'h0000_0200,
          32'hFFFF_FFF8, 32'h0, 32'hFFFF_FFFC, 32'h0,
          32'h0000_0004, 32'hA5A5_0000, 32'h0000_0200, 2'd0},
        '{2'd1, 32'hFFFF_FFFE, 32'h1234_0000, 32'h0000_2000, 32'h0000_3000, 32'h0, 32'h0,
          32'h0000_1FF8, 32'h0000_0000, 32'h0000_1FF4, 32'h0000_3000,
          32'h0000_1FF4, 32'h0000_1FF4, 32'h1234_0000, 2'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_access(input string tag, input logic [31:0] ea, input logic [31:0] ed,
                             input logic ewe, input logic [31:0] rd, input int stall,
                             input bit poke);
        check({tag, " R7 request raised"}, {31'd0, mem_req}, 32'd1);
        for (int s = 0; s < stall; s++) begin
            if (poke && s == 0) begin
                start = 1'b1; op = 2'b10; sp_in = 32'h5555_0000; fp_in = 32'h6666_0000;
                pc_in = 32'h7777_0000; target_in = 32'h8888_0000;
            end
            @(negedge clk);
            start = 1'b0;
            check({tag, " R6 held address"}, mem_addr, ea);
            check({tag, " R6 no advance"}, {30'd0, mem_req, done}, 32'd2);
        end
        check({tag, " R1/R3/R4 address"}, mem_addr, ea);
        check({tag, " R9 write enable"}, {31'd0, mem_we}, {31'd0, ewe});
        check({tag, " R9 byte enables"}, {28'd0, mem_be}, ewe ? 32'hF : 32'h0);
        if (ewe) check({tag, " R1/R2/R3 write data"}, mem_wdata, ed);
        mem_ack = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", {31'd0, busy}, 32'd0);
        check("R10 done/req", {30'd0, done, mem_req}, 32'd0);
        check("R10 sp_out", sp_out, 32'd0);
        check("R10 fp_out", fp_out, 32'd0);
        check("R10 pc_out", pc_out, 32'd0);

        // R8 reserved code ignored
        start = 1'b1; op = 2'b11; sp_in = 32'h100; fp_in = 32'h200;
        @(negedge clk);
        start = 1'b0;
        check("R8 reserved op busy", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R8 reserved op req", {31'd0, mem_req}, 32'd0);
        check("R8 reserved op sp_out", sp_out, 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("vec%0d", i);
            start = 1'b1; op = VEC[i].op; pc_in = VEC[i].pc; target_in = VEC[i].tgt;
            sp_in = VEC[i].sp; fp_in = VEC[i].fp;
            @(negedge clk);
            start = 1'b0;
            check({tag, " R7 busy"}, {31'd0, busy}, 32'd1);
            do_access({tag, ".0"}, VEC[i].a0, VEC[i].d0, VEC[i].op != 2'd2, VEC[i].rd0,
                      int'(VEC[i].stall), i == 0);
            do_access({tag, ".1"}, VEC[i].a1, VEC[i].d1, VEC[i].op != 2'd2, VEC[i].rd1,
                      int'(VEC[i].stall), 1'b0);
            check({tag, " R7 done"}, {31'd0, done}, 32'd1);
            check({tag, " R3/R5 sp_out"}, sp_out, VEC[i].esp);
            check({tag, " R3/R4 fp_out"}, fp_out, VEC[i].efp);
            check({tag, " R2/R5 pc_out"}, pc_out, VEC[i].epc);
            @(negedge clk);
            check({tag, " R7 single done"}, {30'd0, done, busy}, 32'd0);
            check({tag, " R8 outputs hold"}, sp_out, VEC[i].esp);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule